// File: doc/BRIEF.md
# Paged EPROM Programming Sequencer

This controller writes a complete image into a 64 KB EPROM that is reached through a 16 KB window. A two-bit page register inside the part selects which quarter of the array the window shows. After a start pulse, the controller walks the linear address space from zero upward and asks a byte source for each target value. At every page boundary it first loads the page register with a write strobe. It then burns each byte with fixed-length programming pulses. After each pulse it reads the byte back, and it stops pulsing once the read value matches the target. One longer over-programming pulse then follows, whose length is three times the number of pulses the byte needed.

The page register cannot be read back. Once the image is written, the controller therefore selects each page in turn and reads one marker location whose content differs from page to page. It asks the source for that location and its expected value. A byte that fails to verify within the pulse limit, or a marker that reads wrong, ends the run with a fail flag and the failing linear address. A single-cycle done pulse means that the whole image and all page markers were confirmed.

Top module: `pgs_prog_seq`

## Requirements
- R1: For each byte, the controller drives a programming pulse of exactly PULSE_CYC cycles with chip enable low, the level output at code 2 (program), the in-page offset on the address and the target byte on the data output, which stay stable for the whole pulse. A one-cycle verify read follows each pulse, and pulsing repeats until the read byte equals the target. Bytes are visited in rising linear address order.
- R2: After a byte verifies with n pulses, one over-programming pulse of MARGIN_MULT*n*PULSE_CYC cycles (level code 2) follows before the next byte is fetched.
- R3: Before the first byte of each page, and before each page's marker read, a page-select write is issued: chip enable low, level code 1, write enable low for one cycle, and the page number on data bits [PAGE_W-1:0]. The page of a linear address is its top PAGE_W bits and the offset is the rest. Programming selects pages 0,1,2,3 in order, and checking then selects 0,1,2,3 again.
- R4: The level output uses code 0 for a verify read (output enable), code 1 for inactive and code 2 for programming voltage. After reset, and whenever the controller is not busy, chip enable is high, the level is code 1 and write enable is high.
- R5: Chip enable is never high while the level is code 2, and write enable is never low while the level is code 2.
- R6: If a byte has not verified after MAX_PULSES pulses, the controller stops after the last verify read, raises fail_o with the byte's linear address on fail_addr_o, leaves chk_fail_o low and issues no done pulse.
- R7: After all bytes, the controller reads for each page the marker offset that the source gives and compares it with the source's expected value. A mismatch raises fail_o and chk_fail_o, with {page, offset} on fail_addr_o, and ends the run.
- R8: done_o is high for exactly one cycle, and only after all bytes and all page markers have passed. It is never high together with fail_o.
- R9: A start request is taken only while the controller is not busy (idle, done or failed). While busy_o is high, start_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | Run ended with an error (held until next start) |
| chk_fail_o | output | 1 | Error came from a page marker check |
| fail_addr_o | output | ADDR_W | Linear address of the failure |
| src_req_o | output | 1 | Byte fetch from the source this cycle |
| src_addr_o | output | ADDR_W | Linear address requested from the source |
| src_data_i | input | DATA_W | Source byte, valid in the request cycle |
| mark_req_o | output | 1 | Marker lookup this cycle |
| mark_page_o | output | PAGE_W | Page whose marker is wanted |
| mark_off_i | input | ADDR_W-PAGE_W | Marker offset within the page |
| mark_data_i | input | DATA_W | Expected marker value |
| dev_ce_n_o | output | 1 | Device chip enable, active low |
| dev_ovp_o | output | 2 | Output-enable/program-voltage level code |
| dev_we_n_o | output | 1 | Device write enable (page select), active low |
| dev_addr_o | output | ADDR_W-PAGE_W | In-page address to the device |
| dev_dq_o | output | DATA_W | Data to the device |
| dev_dq_i | input | DATA_W | Data read from the device |

## Verification
The bench builds the block with ADDR_W=6, PAGE_W=2 and PULSE_CYC=3, so each page holds 16 bytes. A full image, both sets of page-select writes and every page boundary crossing then fit in a few thousand cycles, and the device model can record every byte's pulse history. The model needs one to three pulses per byte depending on address. That exercises several margin lengths, and a per-address override of 30 pulses reaches the MAX_PULSES=25 limit. A corrupted expected marker on one page drives the page-check failure path.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PS_SET,
        S_PS_WE,
        S_PS_HOLD,
        S_FETCH,
        S_PULSE,
        S_VERIFY,
        S_MARGIN,
        S_ADV,
        S_CK_READ,
        S_DONE,
        S_FAIL
    } pgs_state_e;

    // level codes of the shared output-enable / program-voltage pin
    typedef enum logic [1:0] {
        OVP_READ = 2'd0,
        OVP_IDLE = 2'd1,
        OVP_PROG = 2'd2
    } pgs_ovp_e;

endpackage

// File: rtl/pgs_pulse_timer.sv
module pgs_pulse_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgs_addr_walker.sv
module pgs_addr_walker #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 2,
    localparam int OFF_W = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              last_o,
    output logic              page_end_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (clr_i) begin
            addr_d = '0;
        end else if (inc_i) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o     = addr_q;
    assign page_o     = addr_q[ADDR_W-1 -: PAGE_W];
    assign off_o      = addr_q[OFF_W-1:0];
    assign last_o     = &addr_q;
    assign page_end_o = &addr_q[OFF_W-1:0];
endmodule

// File: rtl/pgs_prog_seq.sv
module pgs_prog_seq
    import pgs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 2,
    parameter int DATA_W      = 8,
    parameter int PULSE_CYC   = 50000,
    parameter int MAX_PULSES  = 25,
    parameter int MARGIN_MULT = 3,
    localparam int OFF_W      = ADDR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              chk_fail_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic              src_req_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic              mark_req_o,
    output logic [PAGE_W-1:0] mark_page_o,
    input  logic [OFF_W-1:0]  mark_off_i,
    input  logic [DATA_W-1:0] mark_data_i,
    output logic              dev_ce_n_o,
    output logic [1:0]        dev_ovp_o,
    output logic              dev_we_n_o,
    output logic [OFF_W-1:0]  dev_addr_o,
    output logic [DATA_W-1:0] dev_dq_o,
    input  logic [DATA_W-1:0] dev_dq_i
);
    localparam int PCNT_W = $clog2(MAX_PULSES + 1);
    localparam int TMR_W  = $clog2(MARGIN_MULT * MAX_PULSES * PULSE_CYC + 1);
    localparam logic [TMR_W-1:0]  PULSE_LAST = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  MARGIN_UNIT = TMR_W'(MARGIN_MULT * PULSE_CYC);
    localparam logic [PCNT_W-1:0] PCNT_MAX = PCNT_W'(MAX_PULSES);
    localparam logic [PAGE_W-1:0] PAGE_LAST = '1;

    typedef struct packed {
        pgs_state_e        st;
        logic [DATA_W-1:0] data;
        logic [PCNT_W-1:0] pcnt;
        logic              chk;
        logic [PAGE_W-1:0] ck_page;
        logic              fail;
        logic              chk_fail;
        logic [ADDR_W-1:0] fail_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              walk_clr, walk_inc;
    logic [ADDR_W-1:0] walk_addr;
    logic [PAGE_W-1:0] walk_page;
    logic [OFF_W-1:0]  walk_off;
    logic              walk_last, walk_page_end;
    logic [TMR_W-1:0]  margin_last;
    logic [PAGE_W-1:0] sel_page;
    pgs_ovp_e          ovp;

    pgs_pulse_timer #(.W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .dec_i  (tmr_dec),
        .zero_o (tmr_zero)
    );

    pgs_addr_walker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (walk_clr),
        .inc_i      (walk_inc),
        .addr_o     (walk_addr),
        .page_o     (walk_page),
        .off_o      (walk_off),
        .last_o     (walk_last),
        .page_end_o (walk_page_end)
    );

    assign margin_last = MARGIN_UNIT * TMR_W'(ctl_q.pcnt) - TMR_W'(1);

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = PULSE_LAST;
        tmr_dec  = 1'b0;
        walk_clr = 1'b0;
        walk_inc = 1'b0;

        case (ctl_q.st)
            S_IDLE, S_DONE, S_FAIL: begin
                if (ctl_q.st == S_DONE) begin
                    ctl_d.st = S_IDLE;
                end
                if (start_i) begin
                    ctl_d.st        = S_PS_SET;
                    ctl_d.fail      = 1'b0;
                    ctl_d.chk_fail  = 1'b0;
                    ctl_d.fail_addr = '0;
                    ctl_d.chk       = 1'b0;
                    ctl_d.ck_page   = '0;
                    walk_clr        = 1'b1;
                end
            end
            S_PS_SET:  ctl_d.st = S_PS_WE;
            S_PS_WE:   ctl_d.st = S_PS_HOLD;
            S_PS_HOLD: ctl_d.st = ctl_q.chk ? S_CK_READ : S_FETCH;
            S_FETCH: begin
                ctl_d.data = src_data_i;
                ctl_d.pcnt = PCNT_W'(1);
                tmr_load   = 1'b1;
                tmr_val    = PULSE_LAST;
                ctl_d.st   = S_PULSE;
            end
            S_PULSE: begin
                tmr_dec = 1'b1;
                if (tmr_zero) begin
                    ctl_d.st = S_VERIFY;
                end
            end
            S_VERIFY: begin
                if (dev_dq_i == ctl_q.data) begin
                    tmr_load = 1'b1;
                    tmr_val  = margin_last;
                    ctl_d.st = S_MARGIN;
                end else if (ctl_q.pcnt == PCNT_MAX) begin
                    ctl_d.fail      = 1'b1;
                    ctl_d.fail_addr = walk_addr;
                    ctl_d.st        = S_FAIL;
                end else begin
                    ctl_d.pcnt = ctl_q.pcnt + PCNT_W'(1);
                    tmr_load   = 1'b1;
                    tmr_val    = PULSE_LAST;
                    ctl_d.st   = S_PULSE;
                end
            end
            S_MARGIN: begin
                tmr_dec = 1'b1;
                if (tmr_zero) begin
                    ctl_d.st = S_ADV;
                end
            end
            S_ADV: begin
                if (walk_last) begin
                    ctl_d.chk     = 1'b1;
                    ctl_d.ck_page = '0;
                    ctl_d.st      = S_PS_SET;
                end else begin
                    walk_inc = 1'b1;
                    ctl_d.st = walk_page_end ? S_PS_SET : S_FETCH;
                end
            end
            S_CK_READ: begin
                if (dev_dq_i != mark_data_i) begin
                    ctl_d.fail      = 1'b1;
                    ctl_d.chk_fail  = 1'b1;
                    ctl_d.fail_addr = {ctl_q.ck_page, mark_off_i};
                    ctl_d.st        = S_FAIL;
                end else if (ctl_q.ck_page == PAGE_LAST) begin
                    ctl_d.st = S_DONE;
                end else begin
                    ctl_d.ck_page = ctl_q.ck_page + PAGE_W'(1);
                    ctl_d.st      = S_PS_SET;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // output decode from the registered state
    assign sel_page = ctl_q.chk ? ctl_q.ck_page : walk_page;

    always_comb begin
        case (ctl_q.st)
            S_PULSE, S_MARGIN:   ovp = OVP_PROG;
            S_VERIFY, S_CK_READ: ovp = OVP_READ;
            default:             ovp = OVP_IDLE;
        endcase
    end

    always_comb begin
        case (ctl_q.st)
            S_PS_SET, S_PS_WE, S_PS_HOLD: dev_dq_o = DATA_W'(sel_page);
            S_PULSE, S_MARGIN:            dev_dq_o = ctl_q.data;
            default:                      dev_dq_o = '0;
        endcase
    end

    assign dev_ovp_o   = ovp;
    assign dev_ce_n_o  = (ctl_q.st == S_IDLE) || (ctl_q.st == S_DONE) || (ctl_q.st == S_FAIL);
    assign dev_we_n_o  = (ctl_q.st != S_PS_WE);
    assign dev_addr_o  = (ctl_q.st == S_CK_READ) ? mark_off_i : walk_off;
    assign busy_o      = !dev_ce_n_o;
    assign done_o      = (ctl_q.st == S_DONE);
    assign fail_o      = ctl_q.fail;
    assign chk_fail_o  = ctl_q.chk_fail;
    assign fail_addr_o = ctl_q.fail_addr;
    assign src_req_o   = (ctl_q.st == S_FETCH);
    assign src_addr_o  = walk_addr;
    assign mark_req_o  = (ctl_q.st == S_CK_READ);
    assign mark_page_o = ctl_q.ck_page;
endmodule

// File: rtl/pgs_prog_seq_chk.sv
module pgs_prog_seq_chk #(
    parameter int OFF_W  = 14,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o,
    input logic              chk_fail_o,
    input logic              dev_ce_n_o,
    input logic [1:0]        dev_ovp_o,
    input logic              dev_we_n_o,
    input logic [OFF_W-1:0]  dev_addr_o,
    input logic [DATA_W-1:0] dev_dq_o
);
    AST_CE_HELD_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ovp_o == 2'd2) |-> !dev_ce_n_o); // R5
    AST_NO_WE_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ovp_o == 2'd2) |-> dev_we_n_o); // R5
    AST_PROG_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ovp_o == 2'd2 && $past(dev_ovp_o) == 2'd2) |-> ($stable(dev_dq_o) && $stable(dev_addr_o))); // R1
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_we_n_o |-> (!dev_ce_n_o && dev_ovp_o == 2'd1)); // R3
    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (dev_ce_n_o && dev_ovp_o == 2'd1 && dev_we_n_o)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !fail_o); // R8
    AST_CHK_FAIL_IS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fail_o |-> fail_o); // R7
endmodule

bind pgs_prog_seq pgs_prog_seq_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .chk_fail_o (chk_fail_o),
    .dev_ce_n_o (dev_ce_n_o),
    .dev_ovp_o  (dev_ovp_o),
    .dev_we_n_o (dev_we_n_o),
    .dev_addr_o (dev_addr_o),
    .dev_dq_o   (dev_dq_o)
);

// File: tb/tb_pgs_prog_seq.sv
`timescale 1ns/1ps
module tb_pgs_prog_seq;
    localparam int AW = 6;
    localparam int PW = 2;
    localparam int OW = AW - PW;
    localparam int DW = 8;
    localparam int P  = 3;
    localparam int MAXP = 25;
    localparam int MM = 3;
    localparam int NB = 1 << AW;
    localparam int PB = 1 << OW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic busy_o, done_o, fail_o, chk_fail_o;
    logic [AW-1:0] fail_addr_o, src_addr_o;
    logic src_req_o, mark_req_o;
    logic [DW-1:0] src_data_i, mark_data_i, dev_dq_o, dev_dq_i;
    logic [PW-1:0] mark_page_o;
    logic [OW-1:0] mark_off_i, dev_addr_o;
    logic dev_ce_n_o, dev_we_n_o;
    logic [1:0] dev_ovp_o;

    always #4 clk = ~clk;

    pgs_prog_seq #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .PULSE_CYC(P),
                   .MAX_PULSES(MAXP), .MARGIN_MULT(MM)) dut (.*);

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- device model and stimulus data ----------------
    int fail_at = -1;
    int bad_page = -1;
    logic [DW-1:0] mem [NB];
    int bursts [NB];
    logic [PW-1:0] dev_page;
    int abort_cnt;
    bit in_burst;
    int blen, baddr;
    bit short_bad;

    function automatic logic [DW-1:0] tdata(int a);
        return DW'((a * 13 + 7) & 127);
    endfunction

    function automatic int need(int a);
        return (a == fail_at) ? 30 : 1 + (a % 3);
    endfunction

    function automatic int mark_lin(int p);
        return p * PB + p + 1;
    endfunction

    assign src_data_i  = tdata(int'(src_addr_o));
    assign mark_off_i  = OW'(mark_page_o) + OW'(1);
    assign mark_data_i = tdata(mark_lin(int'(mark_page_o))) ^
                         ((int'(mark_page_o) == bad_page) ? 8'h01 : 8'h00);
    assign dev_dq_i    = (!dev_ce_n_o && dev_ovp_o == 2'd0) ? mem[{dev_page, dev_addr_o}] : 8'hFF;

    // scoreboard queues
    typedef struct { int a; int n; } exp_t;
    exp_t sbq[$];
    int   pselq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_ovp_o == 2'd2 && dev_ce_n_o) abort_cnt++;
            if (!dev_ce_n_o && !dev_we_n_o) begin
                dev_page = dev_dq_o[PW-1:0];
                if (pselq.size() == 0) begin
                    chk(1'b0, "R3", "unexpected page select", int'(dev_page), -1);
                end else begin
                    int e;
                    e = pselq.pop_front();
                    chk(int'(dev_page) == e, "R3", "page select order", int'(dev_page), e);
                end
            end
            if (dev_ovp_o == 2'd2 && !dev_ce_n_o) begin
                if (!in_burst) begin
                    in_burst = 1'b1;
                    blen = 1;
                    baddr = int'({dev_page, dev_addr_o});
                    bursts[baddr]++;
                    if (bursts[baddr] == need(baddr)) mem[baddr] = mem[baddr] & dev_dq_o;
                end else begin
                    blen++;
                end
            end else if (in_burst) begin
                in_burst = 1'b0;
                if (blen > P) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected margin pulse", baddr, -1);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        chk(baddr == e.a, "R1", "byte order", baddr, e.a);
                        chk(bursts[baddr] - 1 == e.n, "R1", "pulses before verify", bursts[baddr] - 1, e.n);
                        chk(blen == MM * e.n * P, "R2", "margin length", blen, MM * e.n * P);
                        chk(!short_bad, "R1", "pulse length", int'(short_bad), 0);
                    end
                end else if (blen != P) begin
                    short_bad = 1'b1;
                end
            end
        end
    end

    task automatic run(int f_at, int b_pg, bit check_reset);
        int cnt;
        rst_n = 1'b0;
        fail_at = f_at;
        bad_page = b_pg;
        for (int a = 0; a < NB; a++) begin
            mem[a] = 8'hFF;
            bursts[a] = 0;
        end
        dev_page = '0;
        abort_cnt = 0;
        in_burst = 1'b0;
        short_bad = 1'b0;
        sbq.delete();
        pselq.delete();
        for (int a = 0; a < NB; a++) sbq.push_back('{a: a, n: need(a)});
        for (int p = 0; p < 4; p++) pselq.push_back(p);
        for (int p = 0; p <= ((b_pg >= 0) ? b_pg : 3); p++) pselq.push_back(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        if (check_reset) begin
            chk(dev_ce_n_o == 1'b1, "R4", "reset ce_n", int'(dev_ce_n_o), 1);
            chk(dev_ovp_o == 2'd1, "R4", "reset level", int'(dev_ovp_o), 1);
            chk(dev_we_n_o == 1'b1 && !busy_o && !done_o && !fail_o, "R4", "reset flags",
                int'({dev_we_n_o, busy_o, done_o, fail_o}), 8);
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o && !fail_o && cnt < 40000) begin
            @(negedge clk);
            cnt++;
            if (cnt == 10) chk(busy_o == 1'b1, "R9", "busy during run", int'(busy_o), 1);
            start_i = (cnt == 50); // R9: start while busy must be ignored
        end
        start_i = 1'b0;
        chk(cnt < 40000, "R8", "watchdog", cnt, 40000);
    endtask

    initial begin
        // scenario 1: clean image
        run(-1, -1, 1'b1);
        chk(done_o == 1'b1 && fail_o == 1'b0, "R8", "done without fail", int'({done_o, fail_o}), 2);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done one cycle", int'(done_o), 0);
        chk(!busy_o && dev_ce_n_o && dev_ovp_o == 2'd1, "R4", "idle after done",
            int'({busy_o, dev_ce_n_o, dev_ovp_o}), 5);
        begin
            int bad;
            bad = 0;
            for (int a = 0; a < NB; a++) if (mem[a] != tdata(a)) bad++;
            chk(bad == 0, "R1", "programmed image mismatches", bad, 0);
        end
        chk(sbq.size() == 0, "R2", "bytes left unprogrammed", sbq.size(), 0);
        chk(pselq.size() == 0, "R3", "page selects missing", pselq.size(), 0);
        chk(abort_cnt == 0, "R5", "ce high during program level", abort_cnt, 0);
        chk(chk_fail_o == 1'b0, "R7", "marker check clean", int'(chk_fail_o), 0);

        // scenario 2: byte 21 never verifies
        run(21, -1, 1'b0);
        chk(fail_o == 1'b1 && done_o == 1'b0, "R6", "fail flag", int'({fail_o, done_o}), 2);
        chk(int'(fail_addr_o) == 21, "R6", "fail address", int'(fail_addr_o), 21);
        chk(bursts[21] == MAXP, "R6", "pulses on failing byte", bursts[21], MAXP);
        chk(chk_fail_o == 1'b0, "R6", "not a marker failure", int'(chk_fail_o), 0);
        chk(sbq.size() > 0 && sbq[0].a == 21, "R6", "stopped at byte", (sbq.size() > 0) ? sbq[0].a : -1, 21);
        @(negedge clk);
        chk(!busy_o && dev_ce_n_o && fail_o, "R4", "idle levels after fail",
            int'({busy_o, dev_ce_n_o, fail_o}), 3);

        // scenario 3: page 2 marker expected value wrong
        run(-1, 2, 1'b0);
        chk(fail_o && chk_fail_o && !done_o, "R7", "marker failure flags",
            int'({fail_o, chk_fail_o, done_o}), 6);
        chk(int'(fail_addr_o) == mark_lin(2), "R7", "marker fail address", int'(fail_addr_o), mark_lin(2));
        chk(pselq.size() == 0, "R3", "check-phase page selects", pselq.size(), 0);
        chk(sbq.size() == 0, "R1", "image completed before check", sbq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule